// File: doc/BRIEF.md
# Command-Driven I2C Master Engine

This block is a bus master for a two-wire open-drain serial bus. Software performs one primitive bus operation at a time: a start, a repeated start, a byte write (started by loading the byte buffer), the receive of one byte, the send of one acknowledge bit, or a stop. The engine drives each line through an active-high pull-down enable and reads the real line level back. Each operation raises a sticky completion flag when it ends. The `busy` output is the request bit: it clears by itself when the operation ends, so software can poll it.

The engine has no queue. A buffer write that arrives while an operation runs is discarded and flagged as a write collision. Any other command issued during that time is ignored. The clock timing comes from a reloadable divisor. A slave that holds the clock line low stretches the current phase. A data line that reads low while the engine releases it during a driven bit ends the operation as a bus collision. A small bus monitor records whether a start or a stop was seen last. A new start is accepted only while the bus is free.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset `busy` is 0, `sclOe` and `sdaOe` are 0 (both lines released), and `eventFlag`, `wcol`, `bcol`, `startSeen` and `stopSeen` are all 0.
- R2: Every phase lasts `divisor`+1 clocks. The number of phases is 3 for a start, 4 for a repeated start, 3 for a stop, 19 for a byte write, 17 for a byte read and 3 for an acknowledge. A command is accepted on clock edge 1, and `busy` is first seen low after clock edge phases*(divisor+1)+1.
- R3: A byte write puts the buffer on SDA most significant bit first. SDA changes only while SCL is low. SDA is released for a ninth clock, and the SDA level sampled on that clock is stored in `ackStatus` (0 means acknowledged).
- R4: A byte read releases SDA for 8 clocks and samples SDA once per clock, most significant bit first. At completion `bufData` holds the received byte.
- R5: The acknowledge operation drives SDA to the level of `ackValue` (0 pulls low) for one SCL clock pulse.
- R6: `eventFlag` becomes 1 when any operation completes normally. It is cleared by `flagClear`, and a set in the same cycle wins over the clear.
- R7: A buffer write while `busy` is 1 sets `wcol`, leaves `bufData` unchanged and starts no transfer.
- R8: Other commands issued while `busy` is 1 are dropped. They neither change the running operation nor start after it.
- R9: `startSeen` and `stopSeen` record an SDA fall or an SDA rise while SCL is high, and each clears the other. A start command is accepted only when `stopSeen` is 1 or both are 0. Disabling the block clears both and releases the lines.
- R10: While SCL is released but reads low, the phase counter holds. An operation completes exactly one clock later for every stretched clock.
- R11: If SDA reads low at the sample point of a write data bit that drives 1, the engine sets `bcol`, releases both lines and returns to idle without setting `eventFlag`.
- R12: When several commands arrive on the same idle clock, only one is taken, in this priority: buffer write, start, repeated start, stop, acknowledge, receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low releases the lines and clears the bus monitor |
| divisor | input | DIV_W | Phase length minus one, in clocks |
| flagClear | input | 1 | Clears eventFlag, wcol and bcol |
| cmdStart | input | 1 | Request a start |
| cmdRestart | input | 1 | Request a repeated start |
| cmdStop | input | 1 | Request a stop |
| cmdRecv | input | 1 | Request the receive of one byte |
| cmdAck | input | 1 | Request one acknowledge bit |
| ackValue | input | 1 | Level for the acknowledge bit, captured with cmdAck |
| bufWrite | input | 1 | Load the byte buffer and start a byte write |
| wrData | input | DATA_W | Byte for bufWrite |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | An operation is running; clears by itself at its end |
| bufData | output | DATA_W | Byte buffer contents |
| ackStatus | output | 1 | Acknowledge level sampled after the last byte write |
| eventFlag | output | 1 | Sticky completion flag |
| wcol | output | 1 | Sticky write-collision flag |
| bcol | output | 1 | Sticky bus-collision flag |
| startSeen | output | 1 | Last bus condition seen was a start |
| stopSeen | output | 1 | Last bus condition seen was a stop |

## Verification
A wrong phase or step counter shows up first as a wrong `busy` duration. The bench measures that duration to the exact clock for every operation and for several divisors, so a counter that is off by one fails on the first operation. A wrong shift or sample point corrupts the serial pattern captured on SCL rising edges, or the received `bufData`, within one byte. A stuck collision or stretch path shows in `bcol` and in the lines released within two phases, or in an operation that completes too early or too late by the number of stretched clocks.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_START,
    OP_RESTART,
    OP_STOP,
    OP_WRITE,
    OP_READ,
    OP_ACK
  } opKind_e;

  // strobes from the sequencer to the datapath, all single-cycle
  typedef struct packed {
    logic bufLoad;
    logic wcolSet;
    logic ackLoad;
    logic shiftOut;
    logic shiftIn;
    logic ackLatch;
    logic rxCommit;
    logic finish;
    logic collide;
  } dpStrobe_t;

endpackage

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int DIV_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divisor,
  input  logic             cmdStart,
  input  logic             cmdRestart,
  input  logic             cmdStop,
  input  logic             cmdRecv,
  input  logic             cmdAck,
  input  logic             bufWrite,
  input  logic             busFree,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             shiftMsb,
  input  logic             ackDrive,
  output dpStrobe_t        strb,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             busy
);

  localparam int STEP_W = $clog2(2 * DATA_W + 3);
  localparam int BIT_W  = STEP_W - 1;
  localparam logic [STEP_W-1:0] LAST_WRITE = STEP_W'(2 * (DATA_W + 1));
  localparam logic [STEP_W-1:0] LAST_READ  = STEP_W'(2 * DATA_W);

  opKind_e           op;
  opKind_e           nextOp;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] lastStep;
  logic [DIV_W-1:0]  baudCnt;
  logic [BIT_W-1:0]  bitIdx;
  logic              highHalf;
  logic              finalStep;
  logic              dataBit;
  logic              bitOp;
  logic              sclPull;
  logic              sdaPull;
  logic              sclHold;
  logic              sdaHold;
  logic              stall;
  logic              tick;
  logic              collideNow;
  logic              idle;

  assign busy      = (op != OP_IDLE);
  assign idle      = enable && !busy;
  assign bitIdx    = step[STEP_W-1:1];
  assign highHalf  = step[0];
  assign finalStep = (step == lastStep);
  assign dataBit   = (bitIdx < BIT_W'(DATA_W));
  assign bitOp     = (op == OP_WRITE) || (op == OP_READ) || (op == OP_ACK);

  always_comb begin
    unique case (op)
      OP_RESTART: lastStep = STEP_W'(3);
      OP_WRITE:   lastStep = LAST_WRITE;
      OP_READ:    lastStep = LAST_READ;
      default:    lastStep = STEP_W'(2);
    endcase
  end

  // line levels per operation and step (1 = pull low)
  always_comb begin
    sclPull = 1'b0;
    sdaPull = 1'b0;
    unique case (op)
      OP_START: begin
        sclPull = (step == STEP_W'(2));
        sdaPull = (step != STEP_W'(0));
      end
      OP_RESTART: begin
        sclPull = (step == STEP_W'(0)) || (step == STEP_W'(3));
        sdaPull = (step >= STEP_W'(2));
      end
      OP_STOP: begin
        sclPull = (step == STEP_W'(0));
        sdaPull = (step != STEP_W'(2));
      end
      OP_WRITE: begin
        sclPull = !highHalf;
        sdaPull = dataBit && !shiftMsb;
      end
      OP_READ: begin
        sclPull = !highHalf;
        sdaPull = 1'b0;
      end
      OP_ACK: begin
        sclPull = !highHalf;
        sdaPull = ackDrive;
      end
      default: begin
        sclPull = 1'b0;
        sdaPull = 1'b0;
      end
    endcase
  end

  assign sclOe = enable && (busy ? sclPull : sclHold);
  assign sdaOe = enable && (busy ? sdaPull : sdaHold);

  // a released clock that reads low is held by a slave
  assign stall = busy && !sclPull && !sclIn;
  assign tick  = busy && (baudCnt == '0) && !stall;

  assign collideNow = tick && (
      ((op == OP_START) && (step == STEP_W'(0)) && (!sdaIn || !sclIn)) ||
      ((op == OP_WRITE) && highHalf && dataBit && shiftMsb && !sdaIn) ||
      ((op == OP_STOP)  && (step == STEP_W'(2)) && !sdaIn));

  // one command per idle cycle, fixed priority
  always_comb begin
    nextOp = OP_IDLE;
    if (idle) begin
      if (bufWrite)        nextOp = OP_WRITE;
      else if (cmdStart)   nextOp = busFree ? OP_START : OP_IDLE;
      else if (cmdRestart) nextOp = OP_RESTART;
      else if (cmdStop)    nextOp = OP_STOP;
      else if (cmdAck)     nextOp = OP_ACK;
      else if (cmdRecv)    nextOp = OP_READ;
    end
  end

  always_comb begin
    strb          = '0;
    strb.bufLoad  = (nextOp == OP_WRITE);
    strb.ackLoad  = (nextOp == OP_ACK);
    strb.wcolSet  = enable && busy && bufWrite;
    strb.shiftOut = tick && (op == OP_WRITE) && highHalf && dataBit && !collideNow;
    strb.shiftIn  = tick && (op == OP_READ) && highHalf && dataBit;
    strb.ackLatch = tick && (op == OP_WRITE) && highHalf && (bitIdx == BIT_W'(DATA_W));
    strb.rxCommit = tick && (op == OP_READ) && finalStep;
    strb.finish   = tick && finalStep && !collideNow;
    strb.collide  = collideNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op      <= OP_IDLE;
      step    <= '0;
      baudCnt <= '0;
      sclHold <= 1'b0;
      sdaHold <= 1'b0;
    end else if (!enable) begin
      op      <= OP_IDLE;
      sclHold <= 1'b0;
      sdaHold <= 1'b0;
    end else if (!busy) begin
      if (nextOp != OP_IDLE) begin
        op      <= nextOp;
        step    <= '0;
        baudCnt <= divisor;
      end
    end else if (tick) begin
      baudCnt <= divisor;
      if (collideNow) begin
        op      <= OP_IDLE;
        sclHold <= 1'b0;
        sdaHold <= 1'b0;
      end else if (finalStep) begin
        op      <= OP_IDLE;
        sclHold <= sclPull;
        sdaHold <= sdaPull;
      end else begin
        step <= step + 1'b1;
      end
    end else if (!stall) begin
      baudCnt <= baudCnt - 1'b1;
    end
  end

  AST_STALL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sclPull && !sclIn) |=> $stable(baudCnt)); // R10

  AST_COLLIDE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    strb.collide |=> (!sclOe && !sdaOe && !busy)); // R11

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bitOp && !sclPull && $past(busy) && $past(!sclPull)) |-> $stable(sdaPull)); // R3

endmodule

// File: rtl/i2cm_data.sv
module i2cm_data
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              flagClear,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ackValue,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] bufData,
  output logic              shiftMsb,
  output logic              ackDrive,
  output logic              ackStatus,
  output logic              eventFlag,
  output logic              wcol,
  output logic              bcol,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              busFree
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] bufReg;
  logic              sclQ;
  logic              sdaQ;
  logic              startEdge;
  logic              stopEdge;

  assign bufData  = bufReg;
  assign shiftMsb = shiftReg[DATA_W-1];
  assign busFree  = stopSeen || !startSeen;

  assign startEdge = sclQ && sclIn && sdaQ && !sdaIn;
  assign stopEdge  = sclQ && sclIn && !sdaQ && sdaIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bufReg    <= '0;
      ackDrive  <= 1'b0;
      ackStatus <= 1'b0;
    end else begin
      if (strb.bufLoad)
        shiftReg <= wrData;
      else if (strb.shiftOut)
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      else if (strb.shiftIn)
        shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};

      if (strb.bufLoad)       bufReg <= wrData;
      else if (strb.rxCommit) bufReg <= shiftReg;

      if (strb.ackLoad)  ackDrive  <= !ackValue;
      if (strb.ackLatch) ackStatus <= sdaIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventFlag <= 1'b0;
      wcol      <= 1'b0;
      bcol      <= 1'b0;
    end else begin
      eventFlag <= strb.finish  || (eventFlag && !flagClear);
      wcol      <= strb.wcolSet || (wcol && !flagClear);
      bcol      <= strb.collide || (bcol && !flagClear);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (!enable) begin
        startSeen <= 1'b0;
        stopSeen  <= 1'b0;
      end else if (startEdge) begin
        startSeen <= 1'b1;
        stopSeen  <= 1'b0;
      end else if (stopEdge) begin
        startSeen <= 1'b0;
        stopSeen  <= 1'b1;
      end
    end
  end

  AST_WCOL_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wcolSet && !strb.rxCommit) |=> $stable(bufReg)); // R7

  AST_SEEN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(startSeen && stopSeen)); // R9

  AST_ACK_SAMPLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackLatch |-> sclIn); // R3

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              flagClear,
  input  logic              cmdStart,
  input  logic              cmdRestart,
  input  logic              cmdStop,
  input  logic              cmdRecv,
  input  logic              cmdAck,
  input  logic              ackValue,
  input  logic              bufWrite,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              busy,
  output logic [DATA_W-1:0] bufData,
  output logic              ackStatus,
  output logic              eventFlag,
  output logic              wcol,
  output logic              bcol,
  output logic              startSeen,
  output logic              stopSeen
);

  dpStrobe_t strb;
  logic      busFree;
  logic      shiftMsb;
  logic      ackDrive;

  i2cm_ctrl #(.DIV_W(DIV_W), .DATA_W(DATA_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .divisor    (divisor),
    .cmdStart   (cmdStart),
    .cmdRestart (cmdRestart),
    .cmdStop    (cmdStop),
    .cmdRecv    (cmdRecv),
    .cmdAck     (cmdAck),
    .bufWrite   (bufWrite),
    .busFree    (busFree),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .shiftMsb   (shiftMsb),
    .ackDrive   (ackDrive),
    .strb       (strb),
    .sclOe      (sclOe),
    .sdaOe      (sdaOe),
    .busy       (busy)
  );

  i2cm_data #(.DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .flagClear (flagClear),
    .strb      (strb),
    .wrData    (wrData),
    .ackValue  (ackValue),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .bufData   (bufData),
    .shiftMsb  (shiftMsb),
    .ackDrive  (ackDrive),
    .ackStatus (ackStatus),
    .eventFlag (eventFlag),
    .wcol      (wcol),
    .bcol      (bcol),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .busFree   (busFree)
  );

endmodule

// File: tb/sim_i2c_cmd_master.sv
module sim_i2c_cmd_master;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [6:0] divisor = 7'd0;
  logic       flagClear = 1'b0;
  logic       cmdStart = 1'b0, cmdRestart = 1'b0, cmdStop = 1'b0;
  logic       cmdRecv = 1'b0, cmdAck = 1'b0, ackValue = 1'b0, bufWrite = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       sclOe, sdaOe, busy, ackStatus, eventFlag, wcol, bcol, startSeen, stopSeen;
  logic [7:0] bufData;
  logic       sclLine, sdaLine;
  logic       slaveSclLow = 1'b0, forceSdaLow = 1'b0, rxMode = 1'b0, ackMode = 1'b0;
  logic       slaveSdaLow;
  logic [7:0] rxByte = 8'd0;
  logic [7:0] sdaShift;
  logic [4:0] fallCnt = 5'd0;
  logic [8:0] cap = 9'd0;
  logic       prevScl = 1'b1;
  logic       monClr = 1'b0;
  int         errors = 0;
  int         checks = 0;

  always #2 clk = ~clk;

  assign sclLine     = !sclOe && !slaveSclLow;
  assign sdaLine     = !sdaOe && !slaveSdaLow;
  assign sdaShift    = rxByte << fallCnt;
  assign slaveSdaLow = forceSdaLow || (rxMode && (fallCnt < 5'd8) && !sdaShift[7]) ||
                       (ackMode && (fallCnt == 5'd8));

  i2c_cmd_master u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .divisor(divisor), .flagClear(flagClear),
    .cmdStart(cmdStart), .cmdRestart(cmdRestart), .cmdStop(cmdStop), .cmdRecv(cmdRecv),
    .cmdAck(cmdAck), .ackValue(ackValue), .bufWrite(bufWrite), .wrData(wrData),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy),
    .bufData(bufData), .ackStatus(ackStatus), .eventFlag(eventFlag), .wcol(wcol),
    .bcol(bcol), .startSeen(startSeen), .stopSeen(stopSeen)
  );

  // slave-side line monitor, on the falling clock edge
  always @(negedge clk) begin
    if (monClr) begin
      fallCnt <= 5'd0;
      cap     <= 9'd0;
      prevScl <= sclLine;
    end else begin
      prevScl <= sclLine;
      if (prevScl && !sclLine) fallCnt <= fallCnt + 5'd1;
      if (!prevScl && sclLine) cap <= {cap[7:0], sdaLine};
    end
  end

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 0 start, 1 restart, 2 stop, 3 write, 4 receive, 5 ack, 6 write+stop
  task automatic runOp(input int kind, input logic [7:0] data, output int n);
    monClr    = 1'b1;
    flagClear = 1'b1;
    wrData    = data;
    case (kind)
      0: cmdStart = 1'b1;
      1: cmdRestart = 1'b1;
      2: cmdStop = 1'b1;
      3: bufWrite = 1'b1;
      4: cmdRecv = 1'b1;
      5: cmdAck = 1'b1;
      default: begin bufWrite = 1'b1; cmdStop = 1'b1; end
    endcase
    @(posedge clk); #1;
    {cmdStart, cmdRestart, cmdStop, bufWrite, cmdRecv, cmdAck} = '0;
    flagClear = 1'b0;
    monClr    = 1'b0;
    n = 1;
    while (busy && n < 5000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    checkEq("R1 busy", busy, 0);
    checkEq("R1 lines", {sclOe, sdaOe}, 0);
    checkEq("R1 flags", {eventFlag, wcol, bcol, startSeen, stopSeen}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    checkEq("R1 after release", {busy, sclOe, sdaOe, eventFlag, wcol, bcol, startSeen, stopSeen}, 0);
    enable = 1'b1;
    @(posedge clk); #1;

    foreach (divisor[i]) ;
    for (int d = 0; d < 6; d += 2) begin
      int ph;
      divisor = 7'(d);
      ph = d + 1;
      runOp(0, 8'h00, n);
      checkEq("R2 start length", n, 3 * ph + 1);
      checkEq("R9 startSeen after start", {startSeen, stopSeen}, 2);
      checkEq("R6 event after start", eventFlag, 1);
      for (int k = 0; k < 8; k++) begin
        logic [7:0] v;
        v = 8'(k * 53 + 1);
        ackMode = k[0];
        runOp(3, v, n);
        ackMode = 1'b0;
        checkEq("R2 write length", n, 19 * ph + 1);
        checkEq("R3 serial byte", cap[8:1], v);
        checkEq("R3 ack status", ackStatus, k[0] ? 0 : 1);
        checkEq("R6 event after write", eventFlag, 1);
      end
      for (int k = 0; k < 6; k++) begin
        rxByte = 8'(k * 29 + 7);
        rxMode = 1'b1;
        runOp(4, 8'h00, n);
        rxMode = 1'b0;
        checkEq("R2 read length", n, 17 * ph + 1);
        checkEq("R4 received byte", bufData, rxByte);
      end
      for (int a = 0; a < 2; a++) begin
        ackValue = a[0];
        runOp(5, 8'h00, n);
        checkEq("R2 ack length", n, 3 * ph + 1);
        checkEq("R5 ack level", cap[0], a);
        checkEq("R6 event after ack", eventFlag, 1);
      end
      runOp(1, 8'h00, n);
      checkEq("R2 restart length", n, 4 * ph + 1);
      checkEq("R9 startSeen after restart", {startSeen, stopSeen}, 2);
      runOp(2, 8'h00, n);
      checkEq("R2 stop length", n, 3 * ph + 1);
      checkEq("R9 stopSeen after stop", {startSeen, stopSeen}, 1);
      checkEq("R6 event after stop", eventFlag, 1);
      flagClear = 1'b1;
      @(posedge clk); #1;
      flagClear = 1'b0;
      checkEq("R6 cleared", eventFlag, 0);
    end

    divisor = 7'd1;
    runOp(0, 8'h00, n);
    // start with bus owned is refused
    cmdStart = 1'b1;
    @(posedge clk); #1;
    cmdStart = 1'b0;
    checkEq("R9 start refused while bus taken", busy, 0);
    checkEq("R9 no event from refused start", eventFlag, 1);

    // command while busy is dropped
    fork
      runOp(1, 8'h00, n);
      begin
        @(posedge clk); repeat (3) @(posedge clk); #1;
        cmdStop = 1'b1;
        @(posedge clk); #1;
        cmdStop = 1'b0;
      end
    join
    checkEq("R8 restart length unchanged", n, 4 * 2 + 1);
    repeat (4) @(posedge clk);
    #1;
    checkEq("R8 stop not queued", {busy, sdaOe}, 1);

    // buffer write while busy
    ackMode = 1'b1;
    fork
      runOp(3, 8'hA5, n);
      begin
        @(posedge clk); repeat (3) @(posedge clk); #1;
        wrData   = 8'h3C;
        bufWrite = 1'b1;
        @(posedge clk); #1;
        bufWrite = 1'b0;
      end
    join
    checkEq("R7 wcol set", wcol, 1);
    checkEq("R7 buffer kept", bufData, 8'hA5);
    checkEq("R7 byte on bus", cap[8:1], 8'hA5);
    checkEq("R7 write length", n, 19 * 2 + 1);

    // clock stretching
    fork
      runOp(3, 8'h5A, n);
      begin
        slaveSclLow = 1'b1;
        @(negedge clk);
        while (sclOe) @(negedge clk);
        repeat (7) @(posedge clk);
        #1 slaveSclLow = 1'b0;
      end
    join
    checkEq("R10 stretched length", n, 19 * 2 + 1 + 7);
    checkEq("R10 byte intact", cap[8:1], 8'h5A);

    // simultaneous commands: write wins
    runOp(6, 8'hC3, n);
    ackMode = 1'b0;
    checkEq("R12 write taken", n, 19 * 2 + 1);
    checkEq("R12 byte on bus", cap[8:1], 8'hC3);

    // bus collision on a released data bit
    forceSdaLow = 1'b1;
    runOp(3, 8'hFF, n);
    checkEq("R11 ends after first bit", n, 2 * 2 + 1);
    checkEq("R11 bcol", bcol, 1);
    checkEq("R11 lines released", {sclOe, sdaOe, busy}, 0);
    checkEq("R11 no event", eventFlag, 0);
    forceSdaLow = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    checkEq("R9 stop seen on release", {startSeen, stopSeen}, 1);

    // disable clears monitor and releases lines
    runOp(0, 8'h00, n);
    checkEq("R9 start accepted when free", startSeen, 1);
    enable = 1'b0;
    @(posedge clk); #1;
    checkEq("R9 disable clears seen", {startSeen, stopSeen}, 0);
    checkEq("R9 disable releases", {sclOe, sdaOe}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule